// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block keeps the instruction fetch address for a 13-bit program space and the hardware return stack that goes with it. Each clock cycle a 3-bit operation code selects one update of the program counter. It can hold, step by one, take a computed write to its low byte, jump within a 2K-word page, call a subroutine, return from the stack, or branch to the interrupt vector. The low byte of the counter can always be read back. The upper counter bits are never written directly. They come from a separate 5-bit upper-address latch, which software loads through its own write strobe.

Jumps and calls carry an 11-bit immediate. The two page bits above it come from the top two bits of the latch. A return restores all 13 bits from the stack and does not look at the latch. The stack has eight entries and its pointer is hidden. A ninth push with no pop in between overwrites the oldest entry. Pops keep wrapping the same way, and no error is flagged in either direction.

Top module: `paged_pc_stack`

## Requirements
- R1: Reset sets the fetch address and the stack pointer to 0 and clears every stack entry. A return issued straight after reset therefore yields address 0.
- R2: Op code 1 (step) adds one to the 13-bit counter, and 0x1FFF wraps to 0x0000.
- R3: The low-byte readback always equals bits 7:0 of the fetch address.
- R4: Op code 2 (low-byte write) loads bits 7:0 from the write data and bits 12:8 from all five latch bits.
- R5: Op code 3 (jump) loads bits 10:0 from the immediate and bits 12:11 from latch bits 4:3. Latch bits 2:0 have no effect on the result.
- R6: Op code 4 (call) pushes the fetch address plus one, then jumps exactly as R5 does.
- R7: Op code 5 (return) pops the most recent entry into all 13 counter bits, whatever the latch holds.
- R8: Op code 6 (interrupt) pushes the current fetch address unchanged and loads 0x0004.
- R9: Up to eight nested pushes come back in last-in, first-out order.
- R10: The stack pointer wraps modulo 8. After nine pushes the first entry is replaced by the ninth, and further pops continue around the ring.
- R11: Pushes and pops leave the latch unchanged.
- R12: Op code 0 (and the reserved code 7) holds the counter. A latch write becomes visible one cycle later, so an operation issued in the same cycle as a latch write uses the previous latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Operation code for this cycle |
| imm | input | 11 | Jump or call target within the page |
| lo_wdata | input | 8 | Data for a low-byte write |
| latch_we | input | 1 | Write strobe for the upper-address latch |
| latch_wdata | input | 5 | New latch value |
| fetch_addr | output | 13 | Current program counter |
| pc_lo_rd | output | 8 | Readback of the counter's low byte |

## Verification
The bench goes after the wrap points. A counter that does not wrap at 0x1FFF would leave the 13-bit range. A stack that saturates or flags overflow would return the wrong address after the ninth call, and a stack that pops from the wrong slot would break the last-in, first-out order. It sweeps all 32 latch values through low-byte writes and jumps, so a design that takes the wrong latch bits, or lets latch bits 2:0 leak into a jump, shows up as a wrong upper address. It also issues operations in the same cycle as latch writes and after nested calls and interrupts. A design that uses the new latch value too early, pushes the wrong return address for a call versus an interrupt, or disturbs the latch on stack traffic would produce a wrong fetch address.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_INC   = 3'd1,
    OP_LOWWR = 3'd2,
    OP_GOTO  = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5,
    OP_IRQ   = 3'd6,
    OP_RSVD  = 3'd7
  } pc_op_e;

endpackage

// File: rtl/pcs_latch.sv
module pcs_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int LO_W    = 8,
  parameter int IMM_W   = 11,
  parameter int IRQ_VEC = 4,
  localparam int HI_W   = ADDR_W - LO_W,
  localparam int PAGE_W = ADDR_W - IMM_W
) (
  input  pc_op_e            op,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [IMM_W-1:0]  imm,
  input  logic [LO_W-1:0]   lo_wdata,
  input  logic [HI_W-1:0]   latch_q,
  input  logic [ADDR_W-1:0] stk_top,
  output logic [ADDR_W-1:0] pc_d,
  output logic              push_en,
  output logic              pop_en,
  output logic [ADDR_W-1:0] push_data
);

  // Next sequential address, wrapping at the top of the space.
  function automatic logic [ADDR_W-1:0] fn_seq(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + 1'b1);
  endfunction

  // Page-relative target: page bits from the top of the latch.
  function automatic logic [ADDR_W-1:0] fn_page(input logic [HI_W-1:0] l,
                                                input logic [IMM_W-1:0] i);
    return {l[HI_W-1 -: PAGE_W], i};
  endfunction

  // Computed low-byte write: all latch bits supply the high part.
  function automatic logic [ADDR_W-1:0] fn_lowwr(input logic [HI_W-1:0] l,
                                                 input logic [LO_W-1:0] d);
    return {l, d};
  endfunction

  always_comb begin
    pc_d      = pc_q;
    push_en   = 1'b0;
    pop_en    = 1'b0;
    push_data = pc_q;
    unique case (op)
      OP_INC:   pc_d = fn_seq(pc_q);
      OP_LOWWR: pc_d = fn_lowwr(latch_q, lo_wdata);
      OP_GOTO:  pc_d = fn_page(latch_q, imm);
      OP_CALL: begin
        push_en   = 1'b1;
        push_data = fn_seq(pc_q);
        pc_d      = fn_page(latch_q, imm);
      end
      OP_RET: begin
        pop_en = 1'b1;
        pc_d   = stk_top;
      end
      OP_IRQ: begin
        push_en   = 1'b1;
        push_data = pc_q;
        pc_d      = ADDR_W'(IRQ_VEC);
      end
      default: pc_d = pc_q;
    endcase
  end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic            pop_en,
  input  logic [W-1:0]    push_data,
  output logic [W-1:0]    top_q,
  output logic [SP_W-1:0] sp_q
);

  // DEPTH is a power of two, so the pointer wraps by plain overflow.
  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] rd_idx;

  assign rd_idx = SP_W'(sp_q - 1'b1);
  assign top_q  = mem[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (push_en && sp_q == SP_W'(g))   mem[g] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= '0;
    else if (push_en) sp_q <= SP_W'(sp_q + 1'b1);
    else if (pop_en)  sp_q <= SP_W'(sp_q - 1'b1);
  end

endmodule

// File: rtl/paged_pc_stack.sv
module paged_pc_stack
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int LO_W    = 8,
  parameter int IMM_W   = 11,
  parameter int DEPTH   = 8,
  parameter int IRQ_VEC = 4,
  localparam int HI_W   = ADDR_W - LO_W,
  localparam int SP_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [LO_W-1:0]   lo_wdata,
  input  logic              latch_we,
  input  logic [HI_W-1:0]   latch_wdata,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [LO_W-1:0]   pc_lo_rd
);

  pc_op_e            op;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [HI_W-1:0]   latch_q;
  logic [ADDR_W-1:0] stk_top, push_data;
  logic              push_en, pop_en;
  logic [SP_W-1:0]   sp_q;

  assign op = pc_op_e'(op_sel);

  pcs_latch #(.W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .we(latch_we), .wdata(latch_wdata), .q(latch_q)
  );

  pcs_next #(
    .ADDR_W(ADDR_W), .LO_W(LO_W), .IMM_W(IMM_W), .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .op(op), .pc_q(pc_q), .imm(imm), .lo_wdata(lo_wdata), .latch_q(latch_q),
    .stk_top(stk_top), .pc_d(pc_d), .push_en(push_en), .pop_en(pop_en),
    .push_data(push_data)
  );

  pcs_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
    .push_data(push_data), .top_q(stk_top), .sp_q(sp_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign pc_lo_rd   = pc_q[LO_W-1:0];

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int LO_W    = 8,
  parameter int IMM_W   = 11,
  parameter int SP_W    = 3,
  parameter int IRQ_VEC = 4,
  localparam int HI_W   = ADDR_W - LO_W,
  localparam int PAGE_W = ADDR_W - IMM_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_sel,
  input logic [IMM_W-1:0]  imm,
  input logic              latch_we,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [LO_W-1:0]   pc_lo_rd,
  input logic [HI_W-1:0]   latch_q,
  input logic [ADDR_W-1:0] stk_top,
  input logic [ADDR_W-1:0] push_data,
  input logic              push_en,
  input logic [SP_W-1:0]   sp_q
);

  // R3
  lo_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_lo_rd == fetch_addr[LO_W-1:0]);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_INC |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

  // R5
  page_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_GOTO |=>
      fetch_addr == {$past(latch_q[HI_W-1 -: PAGE_W]), $past(imm)});

  // R6
  call_ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_CALL |-> push_data == ADDR_W'(fetch_addr + 1'b1));

  // R7
  pop_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_RET |=> fetch_addr == $past(stk_top));

  // R8
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_IRQ |=> fetch_addr == ADDR_W'(IRQ_VEC) && stk_top == $past(fetch_addr));

  // R10
  sp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> sp_q == SP_W'($past(sp_q) + 1'b1));

  // R11
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_we |=> $stable(latch_q));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_HOLD || op_sel == OP_RSVD) |=> $stable(fetch_addr));

endmodule

bind paged_pc_stack pcs_chk #(
  .ADDR_W(ADDR_W), .LO_W(LO_W), .IMM_W(IMM_W), .SP_W(SP_W), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .imm(imm), .latch_we(latch_we),
  .fetch_addr(fetch_addr), .pc_lo_rd(pc_lo_rd), .latch_q(latch_q),
  .stk_top(stk_top), .push_data(push_data), .push_en(push_en), .sp_q(sp_q)
);

// File: tb/paged_pc_stack_test.sv
`timescale 1ns/1ps
module paged_pc_stack_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [10:0] imm = '0;
  logic [7:0]  lo_wdata = '0;
  logic        latch_we = 1'b0;
  logic [4:0]  latch_wdata = '0;
  logic [12:0] fetch_addr;
  logic [7:0]  pc_lo_rd;

  int total = 0;
  int bad = 0;

  // Bench-side model state
  logic [12:0] m_pc = '0;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp = '0;
  logic [4:0]  m_lat = '0;

  always #2.5 clk = ~clk;

  paged_pc_stack uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .imm(imm), .lo_wdata(lo_wdata),
    .latch_we(latch_we), .latch_wdata(latch_wdata),
    .fetch_addr(fetch_addr), .pc_lo_rd(pc_lo_rd)
  );

  task automatic chk(input string rq, input logic [12:0] act, input logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(input string rq, input logic [2:0] o, input logic [10:0] im,
                      input logic [7:0] lo, input logic lwe, input logic [4:0] ld);
    @(negedge clk);
    op_sel = o; imm = im; lo_wdata = lo; latch_we = lwe; latch_wdata = ld;
    case (o)
      3'd1: m_pc = m_pc + 13'd1;
      3'd2: m_pc = {m_lat, lo};
      3'd3: m_pc = {m_lat[4:3], im};
      3'd4: begin m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; m_pc = {m_lat[4:3], im}; end
      3'd5: begin m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp]; end
      3'd6: begin m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; m_pc = 13'd4; end
      default: ;
    endcase
    if (lwe) m_lat = ld;
    @(posedge clk); #1;
    chk(rq, fetch_addr, m_pc);
    chk("R3", {5'd0, pc_lo_rd}, {5'd0, m_pc[7:0]});
    op_sel = 3'd0; latch_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", fetch_addr, 13'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1: a pop straight after reset sees cleared entries
    step("R1", 3'd5, 11'd0, 8'd0, 1'b0, 5'd0);
    step("R1", 3'd4, 11'd0, 8'd0, 1'b0, 5'd0);

    // R2: step across the top of the space
    step("R12", 3'd0, 11'd0, 8'd0, 1'b1, 5'h1F);
    step("R4", 3'd2, 11'd0, 8'hF0, 1'b0, 5'd0);
    for (int i = 0; i < 40; i++) step("R2", 3'd1, 11'd0, 8'd0, 1'b0, 5'd0);

    // R4/R5/R12: every latch value
    for (int l = 0; l < 32; l++) begin
      step("R12", 3'd0, 11'd0, 8'd0, 1'b1, 5'(l));
      step("R4", 3'd2, 11'd0, 8'(l * 37 + 5), 1'b0, 5'd0);
      step("R5", 3'd3, 11'(l * 61 + 3), 8'd0, 1'b0, 5'd0);
      step("R12", 3'd7, 11'd0, 8'd0, 1'b0, 5'd0);
      // same-cycle latch write must not affect this jump
      step("R12", 3'd3, 11'(l * 13), 8'd0, 1'b1, 5'(31 - l));
      step("R4", 3'd2, 11'd0, 8'(l), 1'b0, 5'd0);
    end

    // R6/R7/R9: nesting depths 1..8
    for (int d = 1; d <= 8; d++) begin
      for (int k = 0; k < d; k++) begin
        step("R6", 3'd4, 11'(d * 100 + k * 7), 8'd0, 1'b1, 5'((d * 5 + k * 3) % 32));
        step("R2", 3'd1, 11'd0, 8'd0, 1'b0, 5'd0);
      end
      step("R12", 3'd0, 11'd0, 8'd0, 1'b1, 5'h15);
      for (int k = 0; k < d; k++) step("R9", 3'd5, 11'd0, 8'd0, 1'b0, 5'd0);
      // R11: latch intact after stack traffic
      step("R11", 3'd2, 11'd0, 8'h3C, 1'b0, 5'd0);
    end

    // R10: overrun and underrun wrap
    for (int k = 0; k < 12; k++) step("R10", 3'd4, 11'(k * 150 + 1), 8'd0, 1'b1, 5'(k * 3));
    for (int k = 0; k < 12; k++) step("R10", 3'd5, 11'd0, 8'd0, 1'b0, 5'd0);

    // R8: interrupts mixed with calls
    step("R4", 3'd2, 11'd0, 8'h77, 1'b1, 5'h0A);
    step("R8", 3'd6, 11'd0, 8'd0, 1'b0, 5'd0);
    step("R2", 3'd1, 11'd0, 8'd0, 1'b0, 5'd0);
    step("R6", 3'd4, 11'h2AA, 8'd0, 1'b0, 5'd0);
    step("R8", 3'd6, 11'd0, 8'd0, 1'b0, 5'd0);
    step("R8", 3'd6, 11'd0, 8'd0, 1'b0, 5'd0);
    for (int k = 0; k < 4; k++) step("R7", 3'd5, 11'd0, 8'd0, 1'b1, 5'(k + 20));
    step("R11", 3'd2, 11'd0, 8'h01, 1'b0, 5'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule